// File: doc/BRIEF.md
# Serial-bus memory slave command controller

This block is the bus-facing front end of a 1 KiB byte-addressed nonvolatile memory. It watches a two-wire serial bus (SCL and SDA) that it samples with its own, much faster system clock. It finds the bus start and stop conditions and decodes the address header. It acknowledges or ignores each access, keeps a 10-bit byte pointer and serves reads from a synchronous memory read port, one cycle of latency. Bytes that the host writes are passed one at a time to a separate write-buffer block. A commit pulse marks the stop that ends a write session.

The header byte carries a fixed device code and a strap bit. It also carries the two high pointer bits, so the 1 KiB array takes four consecutive device codes on the bus. While the write buffer reports busy, the slave stays silent, which lets the host poll for completion with repeated headers. SDA is driven only as an open-drain pull-down enable. The slave never stretches SCL. The system clock must run at least eight times faster than SCL.

Top module: `eepromBusSlave`

## Requirements
- R1: A START (SDA falls while SCL is high) opens an access and a STOP (SDA rises while SCL is high) closes it. Clocked bits seen without a preceding START get no acknowledge and produce no write report, and SDA is released after every STOP.
- R2: The header byte, sent MSB first, holds the code 1010 in bits 7..4, a bit 3 that must equal `strapPin`, pointer bits 9..8 in bits 2..1 and the direction in bit 0 (1 = read, 0 = write). A header that does not match gets no acknowledge, and the slave ignores the bus until the next START.
- R3: The slave acknowledges by holding SDA low through the 9th SCL clock of a matching header, of the byte-address byte and of every data byte it is written.
- R4: The slave samples SDA on the rising edge of SCL and changes its own SDA drive only after a falling edge of SCL. Its drive therefore stays stable while SCL is high, except for the release at a START or STOP.
- R5: Each written data byte produces a one-cycle `wrValid` pulse carrying its target address and value. The address then advances within its 16-byte page only: from offset 15 it wraps to offset 0 and pointer bits 9..4 stay unchanged.
- R6: A STOP that ends a session in which at least one data byte was written produces one `wrCommit` pulse. A session that only sets the pointer produces none.
- R7: A read header with no byte address returns the byte at the current pointer, with bits 9..8 taken from the header. The pointer advances by one after every byte sent.
- R8: A write header and a byte address, then a repeated START and a read header, return the data at the newly loaded pointer.
- R9: During a read, each byte the host acknowledges is followed by the next byte. The pointer counts through the whole array and wraps from 0x3FF to 0x000.
- R10: While `busyIn` is high, the slave does not acknowledge its own header and stays silent for the rest of that access. Once `busyIn` is low the same header is acknowledged.
- R11: After the host does not acknowledge a read byte, the slave releases SDA and keeps it released until the next START or STOP.
- R12: A repeated START in the middle of a byte abandons that byte without a write report and restarts header decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Raw bus clock level |
| sdaIn | input | 1 | Raw bus data level (wired-AND of all drivers) |
| strapPin | input | 1 | Board strap that header bit 3 must equal |
| busyIn | input | 1 | Write buffer is running its internal write cycle |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| memRdAddr | output | 10 | Current byte pointer, memory read address |
| memRdData | input | 8 | Memory read data, valid one cycle after the address |
| wrValid | output | 1 | One-cycle pulse: a data byte was written |
| wrAddr | output | 10 | Target address of the written byte |
| wrData | output | 8 | Value of the written byte |
| wrCommit | output | 1 | One-cycle pulse: a write session has ended |

## Verification
Writes are run with a start offset two bytes short of a page boundary. Three bytes then show page-local wrap apart from a plain increment. Reads are tried in three forms: bare current-address reads, which show that the pointer advances after a read the host did not acknowledge; a random read at 0x3FE, which continues across 0x3FF into 0x000 and separates whole-array wrap from page wrap; and a read that follows a write aborted mid-byte. Headers with a wrong strap bit or a wrong code, clocking without START, and polling while busy show that silence comes only from these causes and that valid accesses are acknowledged.

// File: rtl/eepromBusSlavePkg.sv
package eepromBusSlavePkg;
  localparam int ADDR_W = 10;
  localparam int HI_W = ADDR_W - 8;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEVACK, ST_WADDR, ST_WADDRACK,
    ST_WDATA, ST_WDATAACK, ST_RDATA, ST_RACK
  } ctrlState_t;

  typedef struct packed {
    logic shiftIn;
    logic setPtrHi;
    logic setPtrLo;
    logic emitWrite;
    logic incPtrSeq;
    logic loadTx;
    logic shiftTx;
    logic commit;
  } dpStrobe_t;
endpackage

// File: rtl/busSync.sv
module busSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclQ, sdaQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclQ <= sclPipe[STAGES-1];
      sdaQ <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl = sclPipe[STAGES-1];
  assign sdaLvl = sdaPipe[STAGES-1];
  assign sclRise = sclLvl & ~sclQ;
  assign sclFall = ~sclLvl & sclQ;
  // SDA edges count as bus conditions only while SCL stays high.
  assign startDet = sclLvl & sclQ & sdaQ & ~sdaLvl;
  assign stopDet = sclLvl & sclQ & ~sdaQ & sdaLvl;
endmodule

// File: rtl/busCtrl.sv
module busCtrl
  import eepromBusSlavePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaLvl,
  input  logic [7:0] rxByte,
  input  logic      txBit,
  input  logic      strapPin,
  input  logic      busyIn,
  output dpStrobe_t strobe,
  output logic      sdaOe,
  output logic      devAckPhase
);
  ctrlState_t state;
  logic [3:0] bitCnt;
  logic ackDrive, txActive, isRead, wroteAny, hostAck;
  logic devMatch, byteDone;

  assign devMatch = (rxByte[7:4] == DEV_CODE) && (rxByte[3] == strapPin);
  assign byteDone = sclFall && (bitCnt == 4'd8);

  always_comb begin
    strobe = '0;
    strobe.commit = stopDet && wroteAny;
    if (!startDet && !stopDet) begin
      unique case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          strobe.shiftIn = sclRise && (bitCnt < 4'd8);
          if (byteDone) begin
            strobe.setPtrHi = (state == ST_DEV) && devMatch && !busyIn;
            strobe.setPtrLo = (state == ST_WADDR);
            strobe.emitWrite = (state == ST_WDATA);
          end
        end
        ST_DEVACK: strobe.loadTx = sclFall && isRead;
        ST_RDATA: strobe.shiftTx = sclFall && (bitCnt != 4'd0) && (bitCnt < 4'd8);
        ST_RACK: begin
          strobe.incPtrSeq = sclRise;
          strobe.loadTx = sclFall && hostAck;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
      isRead <= 1'b0;
      wroteAny <= 1'b0;
      hostAck <= 1'b0;
    end else if (startDet) begin
      state <= ST_DEV;
      bitCnt <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
      wroteAny <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (sclRise && (bitCnt < 4'd8)) bitCnt <= bitCnt + 4'd1;
          if (byteDone) begin
            if (state == ST_DEV) begin
              if (devMatch && !busyIn) begin
                ackDrive <= 1'b1;
                isRead <= rxByte[0];
                state <= ST_DEVACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              ackDrive <= 1'b1;
              if (state == ST_WDATA) wroteAny <= 1'b1;
              state <= (state == ST_WADDR) ? ST_WADDRACK : ST_WDATAACK;
            end
          end
        end
        ST_DEVACK, ST_WADDRACK, ST_WDATAACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt <= '0;
            if (state == ST_DEVACK && isRead) begin
              txActive <= 1'b1;
              state <= ST_RDATA;
            end else begin
              state <= (state == ST_DEVACK) ? ST_WADDR : ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          if (byteDone) begin
            txActive <= 1'b0;
            state <= ST_RACK;
          end
        end
        ST_RACK: begin
          if (sclRise) hostAck <= ~sdaLvl;
          if (sclFall) begin
            bitCnt <= '0;
            if (hostAck) begin
              txActive <= 1'b1;
              state <= ST_RDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdaOe = ackDrive | (txActive & ~txBit);
  assign devAckPhase = (state == ST_DEVACK);
endmodule

// File: rtl/busDatapath.sv
module busDatapath
  import eepromBusSlavePkg::*;
#(
  parameter int PAGE_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaLvl,
  input  logic [7:0]        memRdData,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              wrCommit
);
  logic [ADDR_W-1:0] ptr;
  logic [7:0] txShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
      rxByte <= '0;
      txShift <= '1;
      wrValid <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
      wrCommit <= 1'b0;
    end else begin
      wrValid <= strobe.emitWrite;
      wrCommit <= strobe.commit;
      if (strobe.shiftIn) rxByte <= {rxByte[6:0], sdaLvl};
      if (strobe.setPtrHi) ptr[ADDR_W-1:8] <= rxByte[HI_W:1];
      if (strobe.setPtrLo) ptr[7:0] <= rxByte;
      if (strobe.emitWrite) begin
        wrAddr <= ptr;
        wrData <= rxByte;
        ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + PAGE_BITS'(1);
      end
      if (strobe.incPtrSeq) ptr <= ptr + ADDR_W'(1);
      if (strobe.loadTx) txShift <= memRdData;
      else if (strobe.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  assign txBit = txShift[7];
  assign memRdAddr = ptr;
endmodule

// File: rtl/eepromBusSlave.sv
module eepromBusSlave
  import eepromBusSlavePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              strapPin,
  input  logic              busyIn,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              wrCommit
);
  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic txBit, devAckPhase;
  logic [7:0] rxByte;
  dpStrobe_t strobe;

  busSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  busCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .txBit(txBit), .strapPin(strapPin), .busyIn(busyIn),
    .strobe(strobe), .sdaOe(sdaOe), .devAckPhase(devAckPhase)
  );

  busDatapath #(.PAGE_BITS(PAGE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaLvl(sdaLvl),
    .memRdData(memRdData), .rxByte(rxByte), .txBit(txBit),
    .memRdAddr(memRdAddr), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrCommit(wrCommit)
  );
endmodule

// File: rtl/eepromBusSlaveChk.sv
module eepromBusSlaveChk #(
  parameter int ADDR_W = 10,
  parameter int PAGE_BITS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic              sclLvl,
  input logic              startDet,
  input logic              stopDet,
  input logic              busyIn,
  input logic              devAckPhase,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] memRdAddr
);
  assert_release_on_stop_R1: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  assert_release_on_restart_R12: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);

  assert_drive_moves_scl_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !$past(startDet || stopDet)) |-> !sclLvl);

  assert_page_local_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> ((memRdAddr[ADDR_W-1:PAGE_BITS] == wrAddr[ADDR_W-1:PAGE_BITS]) &&
                 (memRdAddr[PAGE_BITS-1:0] == PAGE_BITS'(wrAddr[PAGE_BITS-1:0] + 1'b1))));

  assert_busy_no_header_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    (devAckPhase && !$past(devAckPhase)) |-> !$past(busyIn));
endmodule

bind eepromBusSlave eepromBusSlaveChk #(.ADDR_W(10), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclLvl(sclLvl),
  .startDet(startDet), .stopDet(stopDet), .busyIn(busyIn),
  .devAckPhase(devAckPhase), .wrValid(wrValid), .wrAddr(wrAddr),
  .memRdAddr(memRdAddr)
);

// File: tb/sim_eepromBusSlave.sv
`timescale 1ns/1ps
module sim_eepromBusSlave;
  localparam int Q = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic strapPin = 1'b1;
  logic busyIn = 1'b0;
  logic sdaOe, wrValid, wrCommit;
  logic [9:0] memRdAddr, wrAddr;
  logic [7:0] memRdData = 8'h00, wrData;
  logic sdaBus;
  logic [7:0] mem [0:1023];

  int nChecks = 0, nFail = 0, stableBad = 0;
  int evCnt = 0, commitCnt = 0;
  logic [9:0] evAddr [0:15];
  logic [7:0] evData [0:15];
  bit done = 0;

  assign sdaBus = sdaM & ~sdaOe;

  eepromBusSlave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapPin(strapPin),
    .busyIn(busyIn), .sdaOe(sdaOe), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrCommit(wrCommit)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] memVal(input int a);
    return 8'((a * 37 + 11 + (a >> 8) * 64) & 255);
  endfunction

  initial for (int i = 0; i < 1024; i++) mem[i] = memVal(i);

  always @(posedge clk) begin
    memRdData <= mem[memRdAddr];
    if (wrValid && evCnt < 16) begin
      evAddr[evCnt] <= wrAddr;
      evData[evCnt] <= wrData;
    end
    if (wrValid) evCnt <= evCnt + 1;
    if (wrCommit) commitCnt <= commitCnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic startCond();
    sdaM = 1'b1; sclM = 1'b1; #Q;
    sdaM = 1'b0; #Q;
    sclM = 1'b0; #Q;
  endtask

  task automatic reStart();
    sdaM = 1'b1; #Q;
    sclM = 1'b1; #Q;
    sdaM = 1'b0; #Q;
    sclM = 1'b0; #Q;
  endtask

  task automatic stopCond();
    sdaM = 1'b0; #Q;
    sclM = 1'b1; #Q;
    sdaM = 1'b1; #(2*Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; #Q;
    sclM = 1'b1; #(2*Q);
    sclM = 1'b0; #Q;
  endtask

  // Sends a byte MSB first; ack = 1 when the slave held SDA low on clock 9.
  task automatic writeByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; #Q;
    sclM = 1'b1; #Q;
    ack = ~sdaBus; #Q;
    sclM = 1'b0; #Q;
  endtask

  task automatic readByte(input logic hostAck, output logic [7:0] d);
    logic s1;
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; #Q;
      sclM = 1'b1; #10;
      s1 = sdaBus; #(Q - 10);
      d[i] = sdaBus;
      #(Q - 10);
      if (sdaBus != s1) stableBad++;
      #10;
      sclM = 1'b0; #Q;
    end
    sendBit(~hostAck);
  endtask

  task automatic tReset();
    chk("R1 reset sdaOe", sdaOe, 0);
    chk("R7 reset pointer", memRdAddr, 0);
    chk("R5 reset wrValid", wrValid, 0);
  endtask

  task automatic tNoStart();
    logic ack;
    sclM = 1'b0; #Q;
    writeByte(8'hAA, ack);
    chk("R1 no ack without START", ack, 0);
    writeByte(8'h3C, ack);
    chk("R1 no ack without START second byte", ack, 0);
    stopCond();
    chk("R1 no write report without START", evCnt, 0);
  endtask

  task automatic tMismatch();
    logic ack;
    startCond();
    writeByte(8'hA2, ack);
    chk("R2 strap mismatch nack", ack, 0);
    writeByte(8'h00, ack);
    chk("R2 ignored until next START", ack, 0);
    stopCond();
    startCond();
    writeByte(8'hBA, ack);
    chk("R2 code mismatch nack", ack, 0);
    stopCond();
    chk("R2 no report after mismatch", evCnt, 0);
  endtask

  task automatic tPageWrite();
    logic ack;
    startCond();
    writeByte(8'hAA, ack); chk("R3 header ack", ack, 1);
    writeByte(8'h3E, ack); chk("R3 byte address ack", ack, 1);
    writeByte(8'h5A, ack); chk("R3 data ack 0", ack, 1);
    writeByte(8'hC3, ack); chk("R3 data ack 1", ack, 1);
    writeByte(8'h77, ack); chk("R3 data ack 2", ack, 1);
    stopCond();
    #100;
    chk("R5 report count", evCnt, 3);
    chk("R5 addr 0", evAddr[0], 10'h13E);
    chk("R5 data 0", evData[0], 8'h5A);
    chk("R5 addr 1", evAddr[1], 10'h13F);
    chk("R5 addr 2 page wrap", evAddr[2], 10'h130);
    chk("R5 data 2", evData[2], 8'h77);
    chk("R6 commit after write session", commitCnt, 1);
    chk("R1 released after STOP", sdaOe, 0);
  endtask

  task automatic tCurrentRead();
    logic ack;
    logic [7:0] d;
    startCond();
    writeByte(8'hAB, ack); chk("R7 read header ack", ack, 1);
    readByte(1'b0, d);
    chk("R7 current-address data", d, memVal(10'h131));
    readByte(1'b0, d);
    chk("R11 released after host nack", d, 8'hFF);
    stopCond();
    chk("R4 drive stable while SCL high", stableBad, 0);
    startCond();
    writeByte(8'hAB, ack);
    readByte(1'b0, d);
    chk("R7 pointer advanced after read", d, memVal(10'h132));
    stopCond();
  endtask

  task automatic tRandomWrapRead();
    logic ack;
    logic [7:0] d;
    startCond();
    writeByte(8'hAE, ack); chk("R8 dummy write header ack", ack, 1);
    writeByte(8'hFE, ack); chk("R8 byte address ack", ack, 1);
    reStart();
    writeByte(8'hAF, ack); chk("R8 read header after restart ack", ack, 1);
    readByte(1'b1, d); chk("R8 random read data", d, memVal(10'h3FE));
    readByte(1'b1, d); chk("R9 sequential next", d, memVal(10'h3FF));
    readByte(1'b0, d); chk("R9 wrap to 0x000", d, memVal(10'h000));
    stopCond();
    #100;
    chk("R6 no commit without data", commitCnt, 1);
    chk("R4 drive stable in sequential read", stableBad, 0);
  endtask

  task automatic tBusyPoll();
    logic ack;
    busyIn = 1'b1;
    startCond();
    writeByte(8'hAA, ack); chk("R10 busy header nack", ack, 0);
    writeByte(8'h20, ack); chk("R10 silent for rest of access", ack, 0);
    writeByte(8'h99, ack);
    stopCond();
    chk("R10 no report while busy", evCnt, 3);
    busyIn = 1'b0;
    startCond();
    writeByte(8'hAA, ack); chk("R10 ack after busy clears", ack, 1);
    stopCond();
    #100;
    chk("R6 no commit for poll", commitCnt, 1);
  endtask

  task automatic tRestartAbort();
    logic ack;
    logic [7:0] d;
    startCond();
    writeByte(8'hA8, ack); chk("R12 header ack", ack, 1);
    writeByte(8'h10, ack); chk("R12 byte address ack", ack, 1);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    reStart();
    writeByte(8'hA9, ack); chk("R12 header after abort ack", ack, 1);
    readByte(1'b0, d); chk("R12 read after aborted byte", d, memVal(10'h010));
    stopCond();
    #100;
    chk("R12 partial byte not reported", evCnt, 3);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    #100;
    rstN = 1'b1;
    #100;
    tReset();
    tNoStart();
    tMismatch();
    tPageWrite();
    tCurrentRead();
    tRandomWrapRead();
    tBusyPoll();
    tRestartAbort();
    done = 1;
    summary();
    $finish;
  end
endmodule